// File: doc/BRIEF.md
# I/O Base Relocation Snooper

This block gives a bus peripheral a movable 32-byte I/O window when no configuration memory is fitted to supply its base address. A mode-entry pulse, given once the configuration read has found nothing attached, puts the block into relocation mode. In relocation mode the block answers no bus access at all. It only watches a single fixed snoop port at I/O address 0x378.

To reprogram the block, software first writes a four-byte unlock key to the snoop port, with no interruption. It then sends five more writes to the same port. The first four of these carry the 27-bit window base (address bits 31:5), least significant byte first. The fifth carries a 3-bit interrupt line select. When the fifth write lands, the new base and select take effect together and the block leaves relocation mode. From then on it decodes accesses that fall inside the 32-byte window at the new base.

Top module: `io_reloc_snoop`

## Requirements
- R1: After reset the relocation-mode flag is 0, the base output is 0 and the interrupt select is 0.
- R2: A one-cycle `mode_enter` pulse while the block is outside relocation mode sets `reloc_mode` on the following clock edge.
- R3: While `reloc_mode` is 1, `win_hit` stays 0 for every access, read or write, at any address.
- R4: While in relocation mode, four consecutive writes to address 0x378 carrying the key bytes in order open the programming phase. The key bytes are, in order, KEY[7:0], KEY[15:8], KEY[23:16] and KEY[31:24], with KEY defaulting to 0xA55AC33C.
- R5: A write to 0x378 whose data does not match the expected key byte restarts key matching from the first byte.
- R6: A read of 0x378 during key matching restarts matching from the first byte.
- R7: Accesses to any address other than 0x378 do not disturb key matching.
- R8: In the programming phase, the 1st write to 0x378 supplies base bits 7:5 from data bits 7:5. The 2nd, 3rd and 4th writes supply bits 15:8, 23:16 and 31:24 respectively. The 5th write supplies `irq_sel` from data bits 2:0. After the 5th write, `reloc_mode` is 0 on the next edge.
- R9: `io_base` and `irq_sel` keep their previous values throughout relocation mode. They change only on the edge that ends the mode.
- R10: Outside relocation mode, `win_hit` is asserted combinationally, in the same cycle, when `bus_valid` is 1 and `bus_addr[31:5]` equals `io_base`. Offsets 0 to 31 hit, and the address one past the window does not.
- R11: A `mode_enter` pulse while relocation mode is already active has no effect on key-matching progress.
- R12: Outside relocation mode, writes to 0x378 do not change `io_base` or `irq_sel`.
- R13: Asserting reset at any point, including in the middle of a sequence, clears the base and the interrupt select and leaves relocation mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_enter | input | 1 | Pulse: configuration read found no device |
| bus_valid | input | 1 | An I/O access is present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | I/O address of the access |
| bus_wdata | input | 8 | Write data byte |
| io_base | output | 27 | Window base, address bits 31:5 |
| irq_sel | output | 3 | Selected interrupt line |
| win_hit | output | 1 | Access falls in the window and the block is live |
| reloc_mode | output | 1 | Relocation mode active |

## Verification
Several properties are checked on every cycle by the assertions:
- `win_hit` never rises while relocation mode is active.
- The base and the interrupt select hold steady for as long as the mode lasts.
- The mode only ends on the edge after a write to the snoop port.
- The key-match counter never exceeds its last key index.

Whether the matching actually restarts after a wrong byte or after a read, whether foreign traffic is tolerated, and whether the byte lanes land at the right base bits can only be shown by the bench. It does this through the final base it observes and the window hits at the edges of the new window.

// File: rtl/reloc_pkg.sv
package reloc_pkg;

    localparam int BASE_W   = 27;
    localparam int IRQ_W    = 3;
    localparam int KEY_LEN  = 4;
    localparam int PROG_LEN = 5;
    localparam int CNT_W    = 3;

    typedef enum logic [1:0] {
        ST_LIVE   = 2'd0,
        ST_UNLOCK = 2'd1,
        ST_PROG   = 2'd2
    } reloc_state_e;

    typedef struct packed {
        reloc_state_e        state;
        logic [CNT_W-1:0]    cnt;
        logic [BASE_W-1:0]   shadow;
        logic [BASE_W-1:0]   base;
        logic [IRQ_W-1:0]    irq;
    } reloc_regs_t;

endpackage

// File: rtl/reloc_port_decode.sv
module reloc_port_decode #(
    parameter logic [31:0] PORT_ADDR = 32'h0000_0378
) (
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [31:0] bus_addr,
    output logic        port_wr,
    output logic        port_rd
);
    logic addr_match;

    always_comb begin
        addr_match = bus_valid && (bus_addr == PORT_ADDR);
        port_wr    = addr_match && bus_write;
        port_rd    = addr_match && !bus_write;
    end
endmodule

// File: rtl/reloc_window_decode.sv
module reloc_window_decode #(
    parameter int BASE_W = 27
) (
    input  logic              bus_valid,
    input  logic [BASE_W-1:0] addr_hi,
    input  logic [BASE_W-1:0] base,
    input  logic              mode_active,
    output logic              hit
);
    always_comb begin
        hit = bus_valid && !mode_active && (addr_hi == base);
    end
endmodule

// File: rtl/io_reloc_snoop.sv
module io_reloc_snoop
    import reloc_pkg::*;
#(
    parameter logic [31:0] PORT_ADDR = 32'h0000_0378,
    parameter logic [31:0] KEY       = 32'hA55A_C33C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_enter,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [31:0]       bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [BASE_W-1:0] io_base,
    output logic [IRQ_W-1:0]  irq_sel,
    output logic              win_hit,
    output logic              reloc_mode
);
    localparam logic [CNT_W-1:0] KEY_LAST  = CNT_W'(KEY_LEN - 1);
    localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_LEN - 1);

    reloc_regs_t r_d, r_q;
    logic        port_wr, port_rd;
    logic [7:0]  key_byte;

    reloc_port_decode #(.PORT_ADDR(PORT_ADDR)) u_port (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .port_wr   (port_wr),
        .port_rd   (port_rd)
    );

    reloc_window_decode #(.BASE_W(BASE_W)) u_win (
        .bus_valid   (bus_valid),
        .addr_hi     (bus_addr[31:5]),
        .base        (r_q.base),
        .mode_active (reloc_mode),
        .hit         (win_hit)
    );

    always_comb begin
        key_byte = 8'h00;
        for (int i = 0; i < KEY_LEN; i++) begin
            if (r_q.cnt == CNT_W'(i)) key_byte = KEY[8*i +: 8];
        end
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_LIVE: begin
                if (mode_enter) begin
                    r_d.state = ST_UNLOCK;
                    r_d.cnt   = '0;
                end
            end
            ST_UNLOCK: begin
                if (port_rd) begin
                    r_d.cnt = '0;
                end else if (port_wr) begin
                    if (bus_wdata != key_byte) begin
                        r_d.cnt = '0;
                    end else if (r_q.cnt == KEY_LAST) begin
                        r_d.state = ST_PROG;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_PROG: begin
                if (port_wr) begin
                    case (r_q.cnt)
                        3'd0:    r_d.shadow[2:0]   = bus_wdata[7:5];
                        3'd1:    r_d.shadow[10:3]  = bus_wdata;
                        3'd2:    r_d.shadow[18:11] = bus_wdata;
                        3'd3:    r_d.shadow[26:19] = bus_wdata;
                        default: begin
                            r_d.base = r_q.shadow;
                            r_d.irq  = bus_wdata[IRQ_W-1:0];
                        end
                    endcase
                    if (r_q.cnt == PROG_LAST) begin
                        r_d.state = ST_LIVE;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            default: r_d.state = ST_LIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_LIVE, cnt: '0, shadow: '0, base: '0, irq: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        io_base    = r_q.base;
        irq_sel    = r_q.irq;
        reloc_mode = (r_q.state != ST_LIVE);
    end

    p_no_hit_in_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reloc_mode |-> !win_hit);

    p_enter_sets_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!reloc_mode && mode_enter) |=> reloc_mode);

    p_base_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reloc_mode ##1 reloc_mode |-> ($stable(io_base) && $stable(irq_sel)));

    p_exit_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reloc_mode) |-> $past(port_wr));

    p_key_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_UNLOCK) |-> (r_q.cnt <= KEY_LAST));

    p_live_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !reloc_mode ##1 !reloc_mode |-> ($stable(io_base) && $stable(irq_sel)));
endmodule

// File: tb/io_reloc_snoop_tb.sv
module io_reloc_snoop_tb;
    localparam int NV = 26;
    localparam logic [1:0] OP_NOP = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_EN = 2'd3;
    localparam logic [31:0] PA = 32'h378;
    localparam logic [26:0] NB = 27'h2B1A097;

    // {op, addr, data, exp_hit, exp_mode, exp_base, exp_irq}
    localparam logic [73:0] VEC [NV] = '{
        {OP_RD, 32'h0000_0010, 8'h00, 1'b1, 1'b0, 27'h0, 3'd0}, // R10 base 0
        {OP_EN, 32'h0000_0000, 8'h00, 1'b0, 1'b1, 27'h0, 3'd0}, // R2
        {OP_RD, 32'h0000_0010, 8'h00, 1'b0, 1'b1, 27'h0, 3'd0}, // R3
        {OP_WR, PA,            8'h3C, 1'b0, 1'b1, 27'h0, 3'd0},
        {OP_WR, PA,            8'hC3, 1'b0, 1'b1, 27'h0, 3'd0},
        {OP_WR, PA,            8'h00, 1'b0, 1'b1, 27'h0, 3'd0}, // R5 wrong byte
        {OP_WR, PA,            8'h3C, 1'b0, 1'b1, 27'h0, 3'd0},
        {OP_WR, PA,            8'hC3, 1'b0, 1'b1, 27'h0, 3'd0},
        {OP_RD, PA,            8'h00, 1'b0, 1'b1, 27'h0, 3'd0}, // R6 read restart
        {OP_WR, PA,            8'h3C, 1'b0, 1'b1, 27'h0, 3'd0},
        {OP_WR, 32'h0000_0200, 8'h55, 1'b0, 1'b1, 27'h0, 3'd0}, // R7 foreign write
        {OP_WR, PA,            8'hC3, 1'b0, 1'b1, 27'h0, 3'd0},
        {OP_WR, PA,            8'h5A, 1'b0, 1'b1, 27'h0, 3'd0},
        {OP_EN, 32'h0000_0000, 8'h00, 1'b0, 1'b1, 27'h0, 3'd0}, // R11
        {OP_WR, PA,            8'hA5, 1'b0, 1'b1, 27'h0, 3'd0}, // R4 unlocked
        {OP_WR, PA,            8'hE0, 1'b0, 1'b1, 27'h0, 3'd0}, // R8 bits 7:5
        {OP_WR, PA,            8'h12, 1'b0, 1'b1, 27'h0, 3'd0},
        {OP_WR, PA,            8'h34, 1'b0, 1'b1, 27'h0, 3'd0}, // R9 base held
        {OP_WR, PA,            8'h56, 1'b0, 1'b1, 27'h0, 3'd0},
        {OP_WR, PA,            8'h05, 1'b0, 1'b0, NB,    3'd5}, // R8 commit
        {OP_RD, 32'h5634_12E0, 8'h00, 1'b1, 1'b0, NB,    3'd5}, // R10 offset 0
        {OP_WR, 32'h5634_12FF, 8'h11, 1'b1, 1'b0, NB,    3'd5}, // R10 offset 31
        {OP_RD, 32'h5634_1300, 8'h00, 1'b0, 1'b0, NB,    3'd5}, // R10 one past
        {OP_RD, 32'h5634_12DF, 8'h00, 1'b0, 1'b0, NB,    3'd5}, // R10 one below
        {OP_WR, PA,            8'h3C, 1'b0, 1'b0, NB,    3'd5}, // R12
        {OP_NOP,32'h5634_12E4, 8'h00, 1'b0, 1'b0, NB,    3'd5}  // R10 no valid
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_enter, bus_valid, bus_write;
    logic [31:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [26:0] io_base;
    logic [2:0]  irq_sel;
    logic        win_hit, reloc_mode;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    io_reloc_snoop u_dut (
        .clk(clk), .rst_n(rst_n), .mode_enter(mode_enter),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .io_base(io_base), .irq_sel(irq_sel),
        .win_hit(win_hit), .reloc_mode(reloc_mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [31:0] a, input logic [7:0] d);
        @(negedge clk);
        mode_enter = (op == OP_EN);
        bus_valid  = (op == OP_WR) || (op == OP_RD);
        bus_write  = (op == OP_WR);
        bus_addr   = a;
        bus_wdata  = d;
        #1;
    endtask

    task automatic idle_inputs();
        @(negedge clk);
        mode_enter = 0; bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        mode_enter = 0; bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        rst_n = 0;
        do_reset();
        #1;
        chk("R1 mode", 32'(reloc_mode), 0);
        chk("R1 base", 32'(io_base), 0);
        chk("R1 irq",  32'(irq_sel), 0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][73:72], VEC[i][71:40], VEC[i][39:32]);
            chk($sformatf("R10/R3 hit v%0d", i), 32'(win_hit), 32'(VEC[i][31]));
            @(posedge clk); #1;
            chk($sformatf("R2/R4/R8 mode v%0d", i), 32'(reloc_mode), 32'(VEC[i][30]));
            chk($sformatf("R9/R8 base v%0d", i), 32'(io_base), 32'(VEC[i][29:3]));
            chk($sformatf("R8/R12 irq v%0d", i), 32'(irq_sel), 32'(VEC[i][2:0]));
        end
        idle_inputs();

        // R13: reset during programming clears everything
        apply(OP_EN, 0, 0);
        apply(OP_WR, PA, 8'h3C); apply(OP_WR, PA, 8'hC3);
        apply(OP_WR, PA, 8'h5A); apply(OP_WR, PA, 8'hA5);
        apply(OP_WR, PA, 8'h20);
        do_reset();
        #1;
        chk("R13 mode", 32'(reloc_mode), 0);
        chk("R13 base", 32'(io_base), 0);
        chk("R13 irq",  32'(irq_sel), 0);

        // R4: three key bytes only keep the mode active
        apply(OP_EN, 0, 0);
        apply(OP_WR, PA, 8'h3C); apply(OP_WR, PA, 8'hC3); apply(OP_WR, PA, 8'h5A);
        apply(OP_WR, PA, 8'h00); apply(OP_WR, PA, 8'h00); apply(OP_WR, PA, 8'h00);
        apply(OP_WR, PA, 8'h00); apply(OP_WR, PA, 8'h00);
        @(posedge clk); #1;
        chk("R4 incomplete key", 32'(reloc_mode), 1);

        // R4/R8: full key then program base 0x00000020, irq 2
        apply(OP_WR, PA, 8'h3C); apply(OP_WR, PA, 8'hC3);
        apply(OP_WR, PA, 8'h5A); apply(OP_WR, PA, 8'hA5);
        apply(OP_WR, PA, 8'h20); apply(OP_WR, PA, 8'h00);
        apply(OP_WR, PA, 8'h00); apply(OP_WR, PA, 8'h00);
        apply(OP_WR, PA, 8'h02);
        @(posedge clk); #1;
        chk("R8 mode clear", 32'(reloc_mode), 0);
        chk("R8 base", 32'(io_base), 1);
        chk("R8 irq", 32'(irq_sel), 2);
        apply(OP_RD, 32'h0000_003F, 0);
        chk("R10 hit new base", 32'(win_hit), 1);
        apply(OP_RD, 32'h0000_001F, 0);
        chk("R10 miss old base", 32'(win_hit), 0);
        idle_inputs();

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end
endmodule